// File: doc/BRIEF.md
# Addressable Bit Latch Array with Demultiplex Mode

This block stores a word of single bits that are written one at a time. A single data line is steered into the bit picked by a binary select. Two active-low controls pick one of four modes. With clear idle and the write strobe active, the addressed bit is written. With both idle, every bit holds its value. With clear active and the strobe active, the block acts as an active-high one-of-N router. With clear active and the strobe idle, the block clears. Typical uses are a working register loaded bit by bit, a serial-to-parallel holding register, or a decoder whose selected output carries the data level.

The storage is clocked. The strobe is sampled on the rising clock edge and acts as a write enable. Clear is asynchronous and reaches the outputs without waiting for a clock. The word is built from eight-bit banks. The low three select bits are shared by all banks, and the upper select bits decode to the strobe of exactly one bank, so the width scales by a parameter `N`, which must be a multiple of 8.

Each bank runs a four-state mode selector, with the mode taken from {clear_n, en_n}:
- `MODE_WRITE` (10)
- `MODE_HOLD` (11)
- `MODE_DEMUX` (00)
- `MODE_CLEAR` (01)

The mode follows the controls with no sequencing. Every state can be entered from any other in the cycle in which the controls change. Clear falling enters `MODE_DEMUX` or `MODE_CLEAR`, and clear rising enters `MODE_WRITE` or `MODE_HOLD`. The strobe toggles between `MODE_WRITE` and `MODE_HOLD` when clear is high, and between `MODE_DEMUX` and `MODE_CLEAR` when clear is low. The stored word is a register bank that is reset asynchronously by clear.

Top module: `addr_latch_array`

## Requirements
- R1: The select is plain binary. Select value k addresses output bit q[k]. Bits [2:0] pick the bit within a bank, and the upper bits pick the bank, so 0 is q[0] and N-1 is q[N-1].
- R2: With clear_n=1 and en_n=0 at a rising clock edge, q[sel] takes din after that edge. All other bits keep their values.
- R3: With clear_n=1 and en_n=1 at a rising clock edge, no bit changes, whatever din and sel are.
- R4: While clear_n=0 and en_n=0, q equals din at bit sel and 0 at every other bit. This follows din and sel with no clock edge.
- R5: While clear_n=0 and en_n=1, q is all zero with no clock edge, whatever din and sel are.
- R6: Any period with clear_n=0 empties the storage. After clear_n returns to 1, q is all zero until the next write.
- R7: A write alters only the bank selected by the upper select bits. At most one bank strobe is active at a time, and none is active while en_n=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock that samples writes |
| clear_n | input | 1 | Asynchronous active-low clear; together with en_n, selects demux or clear |
| en_n | input | 1 | Active-low write strobe / demux enable |
| sel | input | $clog2(N) | Binary bit select |
| din | input | 1 | Single data line |
| q | output | N | Parallel output word |

## Verification
A wrong stored bit is visible on q in the first half-cycle after the edge that corrupted it, but only while clear_n is high. Under clear the outputs are driven from the controls, not from storage, so a corrupted store stays hidden until clear is released. For that reason the bench always observes the word in hold mode after a clear. A wrong mode decode shows at once as a changed bit where none should change, or as a nonzero bit under clear. A bank decode fault shows one edge later as a write landing in the wrong eight-bit group.

// File: rtl/albank_pkg.sv
package albank_pkg;

    localparam int BANK_W  = 8;
    localparam int BANK_SW = $clog2(BANK_W);

    // encoding is {clear_n, en_n}
    typedef enum logic [1:0] {
        MODE_DEMUX = 2'b00,
        MODE_CLEAR = 2'b01,
        MODE_WRITE = 2'b10,
        MODE_HOLD  = 2'b11
    } mode_t;

endpackage

// File: rtl/albank_mode_dec.sv
module albank_mode_dec
    import albank_pkg::*;
(
    input  logic  clear_n,
    input  logic  en_n,
    output mode_t mode
);

    always_comb begin
        unique case ({clear_n, en_n})
            2'b00:   mode = MODE_DEMUX;
            2'b01:   mode = MODE_CLEAR;
            2'b10:   mode = MODE_WRITE;
            default: mode = MODE_HOLD;
        endcase
    end

endmodule

// File: rtl/albank_cell8.sv
module albank_cell8
    import albank_pkg::*;
#(
    parameter int W  = BANK_W,
    localparam int SW = $clog2(W)
) (
    input  logic          clk,
    input  logic          clear_n,
    input  logic          en_n,
    input  logic [SW-1:0] sel,
    input  logic          din,
    output logic [W-1:0]  q
);

    mode_t          mode;
    logic [W-1:0]   store;
    logic [W-1:0]   route;

    albank_mode_dec u_dec (
        .clear_n (clear_n),
        .en_n    (en_n),
        .mode    (mode)
    );

    assign route = {{(W-1){1'b0}}, din} << sel;

    // state register: the stored word
    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            store <= '0;
        end else begin
            unique case (mode)
                MODE_WRITE: store[sel] <= din;
                MODE_HOLD,
                MODE_DEMUX,
                MODE_CLEAR: store <= store;
                default:    store <= store;
            endcase
        end
    end

    // output process
    always_comb begin
        unique case (mode)
            MODE_WRITE,
            MODE_HOLD:  q = store;
            MODE_DEMUX: q = route;
            MODE_CLEAR: q = '0;
            default:    q = store;
        endcase
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!clear_n)
        ($past(mode) == MODE_WRITE) |-> (store[$past(sel)] == $past(din))) else $error("write lost"); // R2

    AST_WRITE_LOCAL: assert property (@(posedge clk) disable iff (!clear_n)
        ($past(mode) == MODE_WRITE) |-> (((store ^ $past(store)) & ~({{(W-1){1'b0}}, 1'b1} << $past(sel))) == '0)) else $error("stray bit"); // R2

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!clear_n)
        ($past(mode) == MODE_HOLD && $past(clear_n)) |-> $stable(store)) else $error("hold changed"); // R3

endmodule

// File: rtl/albank_bank_sel.sv
module albank_bank_sel #(
    parameter int NB = 2,
    localparam int UW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          en_n,
    input  logic [UW-1:0] upper,
    output logic [NB-1:0] bank_en_n
);

    generate
        if (NB == 1) begin : g_single
            logic unused_upper;
            assign unused_upper = ^upper;
            assign bank_en_n[0] = en_n;
        end else begin : g_multi
            for (genvar b = 0; b < NB; b++) begin : g_bank
                assign bank_en_n[b] = en_n | (upper != UW'(b));
            end
        end
    endgenerate

endmodule

// File: rtl/addr_latch_array.sv
module addr_latch_array
    import albank_pkg::*;
#(
    parameter int N = 16,
    localparam int SW = $clog2(N),
    localparam int NB = N / BANK_W,
    localparam int UW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          clear_n,
    input  logic          en_n,
    input  logic [SW-1:0] sel,
    input  logic          din,
    output logic [N-1:0]  q
);

    logic [NB-1:0] bank_en_n;
    logic [UW-1:0] upper;

    generate
        if (NB > 1) begin : g_up
            assign upper = sel[SW-1:BANK_SW];
        end else begin : g_noup
            assign upper = '0;
        end
    endgenerate

    albank_bank_sel #(.NB(NB)) u_bsel (
        .en_n      (en_n),
        .upper     (upper),
        .bank_en_n (bank_en_n)
    );

    generate
        for (genvar b = 0; b < NB; b++) begin : g_cell
            albank_cell8 #(.W(BANK_W)) u_cell (
                .clk     (clk),
                .clear_n (clear_n),
                .en_n    (bank_en_n[b]),
                .sel     (sel[BANK_SW-1:0]),
                .din     (din),
                .q       (q[b*BANK_W +: BANK_W])
            );
        end
    endgenerate

    AST_ONE_BANK: assert property (@(posedge clk) disable iff (!clear_n)
        $onehot0(~bank_en_n)) else $error("several banks strobed"); // R7

    AST_IDLE_NO_BANK: assert property (@(posedge clk) disable iff (!clear_n)
        en_n |-> (&bank_en_n)) else $error("bank strobed while idle"); // R7

    always @(negedge clk) begin
        if (clear_n === 1'b0 && en_n === 1'b1) begin
            AST_CLEAR_ZEROES: assert (q == '0) else $error("clear output"); // R5
        end
        if (clear_n === 1'b0 && en_n === 1'b0) begin
            AST_DEMUX_ROUTE: assert (q == ({{(N-1){1'b0}}, din} << sel)) else $error("demux output"); // R4
        end
    end

endmodule

// File: tb/sim_addr_latch_array.sv
`timescale 1ns/1ps
module sim_addr_latch_array;

    localparam int N  = 16;
    localparam int SW = $clog2(N);

    logic          clk = 1'b0;
    logic          clear_n;
    logic          en_n;
    logic [SW-1:0] sel;
    logic          din;
    logic [N-1:0]  q;

    int compared   = 0;
    int mismatched = 0;
    logic [N-1:0] model;

    always #2.5 clk = ~clk;

    addr_latch_array #(.N(N)) u0 (
        .clk (clk), .clear_n (clear_n), .en_n (en_n),
        .sel (sel), .din (din), .q (q)
    );

    function automatic logic [N-1:0] expect_q(logic [N-1:0] m, logic c, logic e,
                                              logic [SW-1:0] s, logic d);
        if (c) return m;
        if (e) return '0;
        return {{(N-1){1'b0}}, d} << s;
    endfunction

    function automatic string req_of(logic c, logic e);
        if (c && !e) return "R2";
        if (c && e)  return "R3";
        if (!e)      return "R4";
        return "R5";
    endfunction

    task automatic check(string req, logic [N-1:0] got, logic [N-1:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: q=%h expected %h", req, got, exp);
        end
    endtask

    // drive at falling edge, check combinational view, then the registered view
    task automatic apply(logic c, logic e, logic [SW-1:0] s, logic d);
        @(negedge clk);
        clear_n = c; en_n = e; sel = s; din = d;
        if (!c) model = '0;
        #1;
        check(req_of(c, e), q, expect_q(model, c, e, s, d));
        @(posedge clk);
        if (c && !e) model[s] = d;
        #1;
        check(req_of(c, e), q, expect_q(model, c, e, s, d));
    endtask

    initial begin
        #1_000_000;
        mismatched++;
        $display("FAIL watchdog: q=%h expected completion", q);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_n = 1'b0; en_n = 1'b1; sel = '0; din = 1'b0;
        model = '0;
        #1;
        check("R5", q, '0);
        repeat (2) @(posedge clk);

        // R6: storage empty after clear release
        apply(1'b1, 1'b1, '0, 1'b1);
        check("R6", q, '0);

        // R1: each address maps to its own bit
        for (int k = 0; k < N; k++) begin
            apply(1'b0, 1'b1, '0, 1'b0);
            apply(1'b1, 1'b0, SW'(k), 1'b1);
            apply(1'b1, 1'b1, '0, 1'b0);
            check("R1", q, N'(1) << k);
        end

        // R7: writes in bank 1 leave bank 0 alone
        apply(1'b0, 1'b1, '0, 1'b0);
        for (int k = 0; k < 8; k++) apply(1'b1, 1'b0, SW'(k), 1'b1);
        for (int k = 8; k < N; k++) apply(1'b1, 1'b0, SW'(k), 1'b0);
        apply(1'b1, 1'b1, '0, 1'b0);
        check("R7", q, {{(N-8){1'b0}}, 8'hFF});

        // R4: demux on every address, both data values
        for (int k = 0; k < N; k++) begin
            apply(1'b0, 1'b0, SW'(k), 1'b1);
            apply(1'b0, 1'b0, SW'(k), 1'b0);
        end

        // R6: stored ones are gone after a demux period
        apply(1'b1, 1'b0, 4'd3, 1'b1);
        apply(1'b0, 1'b0, 4'd5, 1'b1);
        apply(1'b1, 1'b1, 4'd9, 1'b1);
        check("R6", q, '0);

        // constrained random, clear asserted rarely
        for (int i = 0; i < 3000; i++) begin
            logic c;
            c = ($urandom_range(0, 9) != 0);
            apply(c, 1'($urandom), SW'($urandom), 1'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule